// File: doc/BRIEF.md
# Pad Drive Autocalibration Sequencer

This block steps an I/O pad through one drive-strength calibration run. A single-cycle start request latches the bus timing mode and signalling voltage. From those two values it picks a pull-down/pull-up offset pair out of a six-entry table and drives the pair onto the offset field of the calibration configuration register.

The sequencer then stops the card clock, keeping a copy of the clock enable it found. It powers the calibration pad, waits for the pad to settle, and sets the calibration enable together with a one-cycle start strobe. After a further settle time it samples the calibration-active status once per poll interval. When the status reads low, or when the timeout window has run out, it removes pad power first and restores the saved card clock enable one cycle later. If the window ran out, it also clears the calibration enable, loads the fallback offset pair for the latched voltage, and raises a sticky timeout flag.

All delays are counted in clock cycles derived from a clock-frequency parameter and microsecond parameters. The analog calibration is outside the block; it is seen only through the active status input.

Top module: `padcal_seq`

## Requirements
- R1: During reset and in the first cycle after it, every output is 0: offset field, calibration enable, start strobe, pad power, card clock enable, busy, done and timeout.
- R2: On an accepted start, the offset field takes the word {pull-down, pull-up}, with pull-down in bits 15:8. Each table input carries entry k in bits 8k+7:8k, with entries 0 fast SD timing, 1 dual-rate eMMC timing, 2 1.8 V, 3 3.3 V, 4 1.8 V fallback and 5 3.3 V fallback. Selection priority: timing code 1 picks entry 0, timing code 2 picks entry 1, otherwise low_volt_i=1 (1.8 V) picks entry 2 and low_volt_i=0 picks entry 3.
- R3: While idle, card_clk_en_o follows card_clk_en_i one cycle late. While busy it is 0. In the done cycle it equals the card_clk_en_i value sampled in the start cycle.
- R4: Pad power is asserted only while the card clock enable output is 0. Pad power drops at least one cycle before the card clock enable is restored.
- R5: The start strobe is a single-cycle pulse. It is issued with the calibration enable set, while the pad is powered, and no earlier than SETTLE_US after pad power-up. It occurs exactly once per run.
- R6: If the active status reads 0 at a poll sample, the run ends without timeout. The calibration enable stays 1 and the selected offset word stays in place.
- R7: If the status is still 1 at a poll sample taken after the timeout window has elapsed, the run ends with timeout_o=1 and the calibration enable cleared. The offset field then holds entry 4 if the latched voltage is 1.8 V and entry 5 otherwise.
- R8: timeout_o keeps its value until the next accepted start, which clears it in the following cycle.
- R9: A start request while busy is ignored. The run, its offset and its result are unchanged, and no extra done pulse follows.
- R10: done_o is a single-cycle pulse issued once per run, in the cycle the sequencer returns to idle.
- R11: Timing mode and voltage are latched at start, so changing either during a run has no effect on the offset or the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| timing_i | input | 2 | Timing mode code (1 fast SD, 2 dual-rate eMMC, other values legacy) |
| low_volt_i | input | 1 | 1 = 1.8 V signalling, 0 = 3.3 V |
| pu_tab_i | input | 48 | Pull-up offsets, six 8-bit entries |
| pd_tab_i | input | 48 | Pull-down offsets, six 8-bit entries |
| card_clk_en_i | input | 1 | Current card clock enable setting |
| cal_active_i | input | 1 | Calibration-active status |
| ofs_o | output | 16 | Offset field drive {pull-down, pull-up} |
| cal_en_o | output | 1 | Calibration enable drive |
| cal_start_o | output | 1 | Calibration start strobe |
| pad_pwr_o | output | 1 | Calibration pad power drive |
| card_clk_en_o | output | 1 | Card clock enable drive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete pulse |
| timeout_o | output | 1 | Last run timed out |

## Verification
The hardest situations to reach from the ports are an ignored start request that lands in the middle of a run, combined with a card clock input that changes during the run, and a calibration that never finishes. The bench models the analog side as a status flag that rises on the start strobe. The flag either falls after a random delay well inside the window or stays high forever. In disturbed runs the bench pulses start twice, once during the settle phase and once during polling, and flips the clock enable, timing code and voltage mid-run. It then checks that the done-cycle offset, clock restore and fallback all reflect the values latched at the original start.

// File: rtl/padcal_pkg.sv
package padcal_pkg;

   localparam int N_ENT = 6;

   // table entry positions; the bench and the selection depend on them
   localparam int IX_FAST   = 0;
   localparam int IX_DUAL   = 1;
   localparam int IX_LV     = 2;
   localparam int IX_HV     = 3;
   localparam int IX_LV_FB  = 4;
   localparam int IX_HV_FB  = 5;

   typedef enum logic [1:0] {
      TM_LEGACY = 2'd0,
      TM_FAST   = 2'd1,
      TM_DUAL   = 2'd2,
      TM_SPARE  = 2'd3
   } timing_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PAD_ON,
      ST_SETTLE,
      ST_KICK,
      ST_WAIT,
      ST_POLL,
      ST_PAD_OFF,
      ST_RESTORE
   } state_e;

endpackage

// File: rtl/padcal_ofs_sel.sv
module padcal_ofs_sel
   import padcal_pkg::*;
#(
   parameter int OFS_W = 8
) (
   input  logic [N_ENT*OFS_W-1:0] pu_tab_i,
   input  logic [N_ENT*OFS_W-1:0] pd_tab_i,
   input  timing_e                timing_i,
   input  logic                   low_v_i,
   input  logic                   fallback_i,
   output logic [2*OFS_W-1:0]     word_o
);

   localparam int IDX_W = $clog2(N_ENT);

   logic [2*OFS_W-1:0] ent [N_ENT];
   logic [IDX_W-1:0]   idx;

   // pack each table row into a {pull-down, pull-up} word
   for (genvar k = 0; k < N_ENT; k++) begin : g_ent
      assign ent[k] = {pd_tab_i[k*OFS_W +: OFS_W], pu_tab_i[k*OFS_W +: OFS_W]};
   end

   always_comb begin
      if (fallback_i) begin
         idx = low_v_i ? IDX_W'(IX_LV_FB) : IDX_W'(IX_HV_FB);
      end else begin
         unique case (timing_i)
            TM_FAST: idx = IDX_W'(IX_FAST);
            TM_DUAL: idx = IDX_W'(IX_DUAL);
            default: idx = low_v_i ? IDX_W'(IX_LV) : IDX_W'(IX_HV);
         endcase
      end
   end

   assign word_o = ent[idx];

endmodule

// File: rtl/padcal_timer.sv
module padcal_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= len_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   // R5: once expired, the timer stays expired until reloaded
   a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> expired_o);

   // R5: a load of a non-zero length always starts a wait
   a_r5_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && len_i != '0) |=> !expired_o);

endmodule

// File: rtl/padcal_seq.sv
module padcal_seq
   import padcal_pkg::*;
#(
   parameter int OFS_W      = 8,
   parameter int CLK_MHZ    = 250,
   parameter int SETTLE_US  = 2,
   parameter int POLL_US    = 1000,
   parameter int TIMEOUT_US = 10000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [1:0]             timing_i,
   input  logic                   low_volt_i,
   input  logic [N_ENT*OFS_W-1:0] pu_tab_i,
   input  logic [N_ENT*OFS_W-1:0] pd_tab_i,
   input  logic                   card_clk_en_i,
   input  logic                   cal_active_i,
   output logic [2*OFS_W-1:0]     ofs_o,
   output logic                   cal_en_o,
   output logic                   cal_start_o,
   output logic                   pad_pwr_o,
   output logic                   card_clk_en_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   timeout_o
);

   localparam int SETTLE_CYC  = CLK_MHZ * SETTLE_US;
   localparam int POLL_CYC    = CLK_MHZ * POLL_US;
   localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
   localparam int MAX_A       = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
   localparam int MAX_CYC     = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
   localparam int CNT_W       = $clog2(MAX_CYC + 1);

   if (OFS_W < 1 || SETTLE_CYC < 1 || POLL_CYC < 1 || TIMEOUT_CYC < POLL_CYC) begin : g_bad_cfg
      $error("padcal_seq: offset width, settle, poll and timeout lengths must be positive, timeout >= poll");
   end

   state_e              state_q;
   timing_e             tm_q;
   logic                lowv_q;
   logic                clk_save_q;
   logic                card_clk_q;
   logic                pad_q;
   logic                cal_en_q;
   logic                kick_q;
   logic                done_q;
   logic                to_q;
   logic [2*OFS_W-1:0]  ofs_q;

   timing_e             sel_tm;
   logic                sel_lowv;
   logic                sel_fb;
   logic [2*OFS_W-1:0]  sel_word;

   logic                ivl_load;
   logic [CNT_W-1:0]    ivl_len;
   logic                ivl_exp;
   logic                win_load;
   logic                win_exp;

   logic                idle;
   assign idle = (state_q == ST_IDLE);

   // selection reads live inputs at start, latched values afterwards
   assign sel_tm   = idle ? timing_e'(timing_i) : tm_q;
   assign sel_lowv = idle ? low_volt_i : lowv_q;
   assign sel_fb   = (state_q == ST_RESTORE);

   padcal_ofs_sel #(.OFS_W(OFS_W)) i_sel (
      .pu_tab_i   (pu_tab_i),
      .pd_tab_i   (pd_tab_i),
      .timing_i   (sel_tm),
      .low_v_i    (sel_lowv),
      .fallback_i (sel_fb),
      .word_o     (sel_word)
   );

   // interval timer: settle delays and poll period
   always_comb begin
      ivl_load = 1'b0;
      ivl_len  = CNT_W'(SETTLE_CYC);
      win_load = 1'b0;
      unique case (state_q)
         ST_PAD_ON: ivl_load = 1'b1;
         ST_KICK:   ivl_load = 1'b1;
         ST_WAIT: begin
            if (ivl_exp) begin
               ivl_load = 1'b1;
               ivl_len  = CNT_W'(POLL_CYC);
               win_load = 1'b1;
            end
         end
         ST_POLL: begin
            if (ivl_exp && cal_active_i && !win_exp) begin
               ivl_load = 1'b1;
               ivl_len  = CNT_W'(POLL_CYC);
            end
         end
         default: ;
      endcase
   end

   padcal_timer #(.CNT_W(CNT_W)) i_ivl (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ivl_load),
      .len_i     (ivl_len),
      .expired_o (ivl_exp)
   );

   // overall timeout window, started with the first poll period
   padcal_timer #(.CNT_W(CNT_W)) i_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (win_load),
      .len_i     (CNT_W'(TIMEOUT_CYC)),
      .expired_o (win_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         tm_q       <= TM_LEGACY;
         lowv_q     <= 1'b0;
         clk_save_q <= 1'b0;
         card_clk_q <= 1'b0;
         pad_q      <= 1'b0;
         cal_en_q   <= 1'b0;
         kick_q     <= 1'b0;
         done_q     <= 1'b0;
         to_q       <= 1'b0;
         ofs_q      <= '0;
      end else begin
         kick_q <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               card_clk_q <= card_clk_en_i;
               if (start_i) begin
                  tm_q       <= timing_e'(timing_i);
                  lowv_q     <= low_volt_i;
                  clk_save_q <= card_clk_en_i;
                  card_clk_q <= 1'b0;
                  to_q       <= 1'b0;
                  ofs_q      <= sel_word;
                  state_q    <= ST_PAD_ON;
               end
            end
            ST_PAD_ON: begin
               pad_q   <= 1'b1;
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (ivl_exp) state_q <= ST_KICK;
            end
            ST_KICK: begin
               cal_en_q <= 1'b1;
               kick_q   <= 1'b1;
               state_q  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (ivl_exp) state_q <= ST_POLL;
            end
            ST_POLL: begin
               if (ivl_exp) begin
                  if (!cal_active_i) begin
                     state_q <= ST_PAD_OFF;
                  end else if (win_exp) begin
                     to_q    <= 1'b1;
                     state_q <= ST_PAD_OFF;
                  end
               end
            end
            ST_PAD_OFF: begin
               pad_q   <= 1'b0;
               state_q <= ST_RESTORE;
            end
            ST_RESTORE: begin
               card_clk_q <= clk_save_q;
               if (to_q) begin
                  cal_en_q <= 1'b0;
                  ofs_q    <= sel_word;
               end
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ofs_o         = ofs_q;
   assign cal_en_o      = cal_en_q;
   assign cal_start_o   = kick_q;
   assign pad_pwr_o     = pad_q;
   assign card_clk_en_o = card_clk_q;
   assign busy_o        = !idle;
   assign done_o        = done_q;
   assign timeout_o     = to_q;

   // R3: card clock held off throughout a run
   a_r3_clk_off_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !card_clk_en_o);

   // R4: pad is powered only with the card clock stopped
   a_r4_pad_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pwr_o |-> !card_clk_en_o);

   // R4: pad power is already gone when the clock is about to be restored
   a_r4_pad_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RESTORE) |-> !pad_pwr_o);

   // R5: strobe only with pad up and enable set, and only for one cycle
   a_r5_kick_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> (pad_pwr_o && cal_en_o));
   a_r5_kick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |=> !cal_start_o);

   // R7: a timed-out run ends with calibration disabled
   a_r7_to_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> !cal_en_o);

   // R6: a successful run leaves calibration enabled
   a_r6_ok_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !timeout_o) |-> cal_en_o);

   // R10: done is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9, R11: offset field frozen while the run waits and polls
   a_r9_ofs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && state_q != ST_RESTORE) |=> $stable(ofs_o));

endmodule

// File: tb/test_padcal_seq.sv
`timescale 1ns/1ps
module test_padcal_seq;

   localparam int OFS_W = 8;
   localparam int NE    = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start_i = 1'b0;
   logic [1:0]           timing_i = 2'd0;
   logic                 low_volt_i = 1'b0;
   logic [NE*OFS_W-1:0]  pu_tab_i = '0;
   logic [NE*OFS_W-1:0]  pd_tab_i = '0;
   logic                 card_clk_en_i = 1'b0;
   logic                 cal_active_i = 1'b0;
   logic [2*OFS_W-1:0]   ofs_o;
   logic                 cal_en_o, cal_start_o, pad_pwr_o, card_clk_en_o;
   logic                 busy_o, done_o, timeout_o;

   int nchk = 0;
   int nfail = 0;
   int act_left = 0;
   int act_delay = 10;
   bit act_never = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   // counting parameters kept small so runs stay short
   padcal_seq #(.OFS_W(OFS_W), .CLK_MHZ(4), .SETTLE_US(1), .POLL_US(3), .TIMEOUT_US(30)) i_padcal_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .timing_i(timing_i),
      .low_volt_i(low_volt_i), .pu_tab_i(pu_tab_i), .pd_tab_i(pd_tab_i),
      .card_clk_en_i(card_clk_en_i), .cal_active_i(cal_active_i),
      .ofs_o(ofs_o), .cal_en_o(cal_en_o), .cal_start_o(cal_start_o),
      .pad_pwr_o(pad_pwr_o), .card_clk_en_o(card_clk_en_o), .busy_o(busy_o),
      .done_o(done_o), .timeout_o(timeout_o));

   // analog model: active rises on the strobe, falls after act_delay cycles
   always @(negedge clk) begin
      if (cal_start_o) begin
         cal_active_i <= 1'b1;
         act_left     <= act_delay;
      end else if (cal_active_i && !act_never && act_left > 0) begin
         act_left <= act_left - 1;
         if (act_left == 1) cal_active_i <= 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ent_word(input int k);
      return {pd_tab_i[k*OFS_W +: OFS_W], pu_tab_i[k*OFS_W +: OFS_W]};
   endfunction

   function automatic int exp_index(input logic [1:0] tm, input logic lv);
      if (tm == 2'd1) return 0;
      if (tm == 2'd2) return 1;
      return lv ? 2 : 3;
   endfunction

   task automatic run_one(input logic [1:0] tm, input logic lv, input logic ce,
                          input int dly, input bit never, input bit disturb);
      logic [15:0] exp_ofs;
      int kicks = 0, clk_bad = 0, kick_bad = 0, dones = 0, cyc = 0;
      logic prev_pad = 1'b0;
      bit   pad_order_bad = 1'b0;
      logic prev_to;
      exp_ofs = never ? ent_word(lv ? 4 : 5) : ent_word(exp_index(tm, lv));
      act_delay = dly;
      act_never = never;
      @(negedge clk);
      prev_to = timeout_o;
      timing_i = tm; low_volt_i = lv; card_clk_en_i = ce; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R8 timeout cleared by start", {31'd0, timeout_o}, 32'd0);
      chk("R2 offset selected at start", {16'd0, ofs_o}, {16'd0, ent_word(exp_index(tm, lv))});
      forever begin
         if (busy_o && card_clk_en_o) clk_bad++;
         if (cal_start_o) begin
            kicks++;
            if (!pad_pwr_o || !cal_en_o) kick_bad++;
         end
         if (done_o) break;
         if (disturb && (cyc == 3 || cyc == 20)) begin
            start_i = 1'b1; timing_i = ~tm; low_volt_i = ~lv; card_clk_en_i = ~ce;
         end else begin
            start_i = 1'b0;
         end
         prev_pad = pad_pwr_o;
         @(negedge clk);
         if (!busy_o && !done_o) break;
         cyc++;
         if (cyc > 2000) break;
      end
      start_i = 1'b0;
      if (prev_pad) pad_order_bad = 1'b1;
      chk("R10 done reached", {31'd0, done_o}, 32'd1);
      chk("R3 clock off while busy", clk_bad, 0);
      chk("R5 single strobe", kicks, 1);
      chk("R5 strobe context", kick_bad, 0);
      chk("R4 pad off before restore", {31'd0, pad_order_bad | pad_pwr_o}, 32'd0);
      chk("R3 saved clock restored", {31'd0, card_clk_en_o}, {31'd0, ce});
      if (never) begin
         chk("R7 timeout flag", {31'd0, timeout_o}, 32'd1);
         chk("R7 enable cleared", {31'd0, cal_en_o}, 32'd0);
         chk("R7 fallback offset", {16'd0, ofs_o}, {16'd0, exp_ofs});
      end else begin
         chk("R6 no timeout", {31'd0, timeout_o}, 32'd0);
         chk("R6 enable kept", {31'd0, cal_en_o}, 32'd1);
         chk(disturb ? "R11 latched offset" : "R6 offset kept", {16'd0, ofs_o}, {16'd0, exp_ofs});
      end
      prev_to = timeout_o;
      @(negedge clk);
      chk("R10 done single cycle", {31'd0, done_o}, 32'd0);
      for (int i = 0; i < 15; i++) begin
         if (done_o) dones++;
         @(negedge clk);
      end
      chk(disturb ? "R9 no extra run" : "R10 no extra done", {dones, busy_o}, 32'd0);
      chk("R8 timeout held", {31'd0, timeout_o}, {31'd0, prev_to});
      chk("R3 idle follows input", {31'd0, card_clk_en_o}, {31'd0, card_clk_en_i});
   endtask

   initial begin
      void'($urandom(32'h5eed_0c41));
      for (int k = 0; k < NE; k++) begin
         pu_tab_i[k*OFS_W +: OFS_W] = 8'h10 + 8'(k);
         pd_tab_i[k*OFS_W +: OFS_W] = 8'hA0 + 8'(k);
      end
      card_clk_en_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {ofs_o, 9'd0, cal_en_o, cal_start_o, pad_pwr_o,
           card_clk_en_o, busy_o, done_o, timeout_o}, 32'd0);
      rst_n = 1'b1;
      chk("R1 first cycle after reset", {31'd0, busy_o | done_o | card_clk_en_o}, 32'd0);
      // directed: every timing code at both voltages
      for (int t = 0; t < 4; t++) begin
         for (int v = 0; v < 2; v++) begin
            run_one(2'(t), 1'(v), 1'(t[0] ^ v[0]), 5 + t * 7, 1'b0, 1'b0);
         end
      end
      // directed: timeout at both voltages, then recovery
      run_one(2'd1, 1'b1, 1'b1, 0, 1'b1, 1'b0);
      run_one(2'd0, 1'b0, 1'b0, 0, 1'b1, 1'b1);
      run_one(2'd2, 1'b1, 1'b1, 1, 1'b0, 1'b1);
      // random mix
      for (int n = 0; n < 30; n++) begin
         pu_tab_i = {$urandom(), $urandom()};
         pd_tab_i = {$urandom(), $urandom()};
         run_one(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom_range(1, 60),
                 ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule